// File: doc/BRIEF.md
# Packed SIMD Saturating Adder

This block adds or subtracts two 128-bit operands as a set of independent packed lanes. The lane size is chosen for each operation: sixteen 8-bit lanes, eight 16-bit lanes or four 32-bit lanes. Every lane is computed in parallel. No carry or borrow ever crosses a lane boundary.

A lane can be read as a signed or an unsigned number. The result can wrap modulo the lane width, or it can saturate. In saturating mode, a lane that leaves its range is pinned to the nearest extreme of that range. The block takes a new operation on every clock and presents the registered result one edge later. A sticky flag records that at least one lane was clamped since the last explicit clear.

Top module: `simd_sat_add`

## Requirements
- R1: The result and the flag are registered. The inputs sampled at a rising edge appear on `res_o` and `sat_o` after that same edge, and a new operation is accepted at every edge. While `rst_ni` is low, `res_o` is 0 and `sat_o` is 0.
- R2: `size_i` selects the lanes. A value of 0 gives 16 lanes of 8 bits, 1 gives 8 lanes of 16 bits, and both 2 and 3 give 4 lanes of 32 bits. Lane k occupies bits [k*w +: w], where w is the lane width. No carry or borrow passes from one lane into the next.
- R3: With `sub_i`=0 each lane computes A+B. With `sub_i`=1 each lane computes A-B, formed as A plus the inverted B plus one inside the lane.
- R4: With `sat_i`=0 each lane result is the exact result modulo 2^w, for both signed and unsigned operands.
- R5: With `sat_i`=1 and `signed_i`=0, a lane whose add carries out becomes all ones, and a lane whose subtract borrows becomes all zeros.
- R6: With `sat_i`=1 and `signed_i`=1, a lane whose true result exceeds 2^(w-1)-1 becomes 2^(w-1)-1, and a lane whose true result is below -2^(w-1) becomes -2^(w-1).
- R7: `sat_o` becomes 1 after any operation in which at least one lane clamps. It then stays 1 until it is cleared.
- R8: `clr_i`=1 returns `sat_o` to 0 at the same edge. If that same operation clamps a lane, `sat_o` is 1 after the edge instead.
- R9: An operation with `sat_i`=0 never sets `sat_o`, even when a lane overflows.
- R10: When B is all zeros, `res_o` equals A for every lane size, sign mode, saturation mode and direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 128 | Operand A, packed lanes |
| b_i | input | 128 | Operand B, packed lanes |
| size_i | input | 2 | Lane size code (0: 8-bit, 1: 16-bit, 2/3: 32-bit) |
| signed_i | input | 1 | Lanes read as two's complement when 1 |
| sat_i | input | 1 | Saturate on overflow when 1, wrap when 0 |
| sub_i | input | 1 | Subtract B from A when 1 |
| clr_i | input | 1 | Clear the sticky saturation flag |
| res_o | output | 128 | Registered packed result |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
A clear request and a lane clamp can arrive in the same operation, and the flag register must then end up set. The bench provokes this by issuing a saturating operation with operands at a lane extreme while `clr_i` is high. It then issues a plain clear with no clamp and expects the flag to return to 0. Its scoreboard keeps its own running model of the flag, so each of these edges is judged against the state the requirements predict. Lane isolation is covered as well: all-ones plus one in 8-bit lanes must give zero in every byte, with nothing carried into the neighbouring lane.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;

  typedef enum logic [1:0] {
    LANE_B8  = 2'd0,
    LANE_H16 = 2'd1,
    LANE_W32 = 2'd2,
    LANE_W32X = 2'd3
  } lane_size_e;

  // segment-index mask: set bits select segments that belong to one lane
  function automatic logic [1:0] seg_mask(input logic [1:0] size);
    case (size)
      LANE_B8:  seg_mask = 2'b00;
      LANE_H16: seg_mask = 2'b01;
      default:  seg_mask = 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/simd_seg_adder.sv
module simd_seg_adder #(
  parameter int DATA_W = 128,
  parameter int SEG_W  = 8,
  localparam int NSEG  = DATA_W / SEG_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic [1:0]        mask_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [NSEG-1:0]   cout_o
);

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    logic              cin;
    logic [SEG_W-1:0]  bb;
    logic [SEG_W:0]    s;

    if (k == 0) begin : g_first
      assign cin = sub_i;
    end else begin : g_rest
      // lane start segments take the subtract carry-in, others chain
      assign cin = ((2'(k) & mask_i) == 2'b00) ? sub_i : cout_o[k-1];
    end

    assign bb = b_i[k*SEG_W +: SEG_W] ^ {SEG_W{sub_i}};
    assign s  = {1'b0, a_i[k*SEG_W +: SEG_W]} + {1'b0, bb} + {{SEG_W{1'b0}}, cin};
    assign sum_o[k*SEG_W +: SEG_W] = s[SEG_W-1:0];
    assign cout_o[k] = s[SEG_W];
  end

endmodule

// File: rtl/simd_lane_clamp.sv
module simd_lane_clamp #(
  parameter int DATA_W = 128,
  parameter int SEG_W  = 8,
  localparam int NSEG  = DATA_W / SEG_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] sum_i,
  input  logic [NSEG-1:0]   cout_i,
  input  logic [1:0]        mask_i,
  input  logic              signed_i,
  input  logic              sat_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] res_o,
  output logic              clamp_any_o
);

  logic [NSEG-1:0] last;   // segment holds lane MSB
  logic [NSEG-1:0] ov;     // overflow, valid on last segments
  logic [NSEG-1:0] hi;     // clamp direction: 1 = max, 0 = min

  always_comb begin
    for (int k = 0; k < NSEG; k++) begin
      logic sa, sb, sr;
      sa = a_i[k*SEG_W + SEG_W-1];
      sb = b_i[k*SEG_W + SEG_W-1] ^ sub_i;
      sr = sum_i[k*SEG_W + SEG_W-1];
      last[k] = ((2'(k) & mask_i) == mask_i);
      if (signed_i) begin
        ov[k] = last[k] & (sa == sb) & (sr != sa);
        hi[k] = ~sa;
      end else begin
        ov[k] = last[k] & (sub_i ? ~cout_i[k] : cout_i[k]);
        hi[k] = ~sub_i;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NSEG; k++) begin
      int e;
      logic [SEG_W-1:0] fill;
      e = k | int'(mask_i);
      if (hi[e]) fill = {SEG_W{1'b1}};
      else       fill = {SEG_W{1'b0}};
      if (signed_i && last[k]) fill[SEG_W-1] = ~hi[e];
      res_o[k*SEG_W +: SEG_W] = (sat_i && ov[e]) ? fill : sum_i[k*SEG_W +: SEG_W];
    end
  end

  assign clamp_any_o = sat_i & (|ov);

endmodule

// File: rtl/simd_sat_add.sv
module simd_sat_add
  import simd_sat_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int SEG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        size_i,
  input  logic              signed_i,
  input  logic              sat_i,
  input  logic              sub_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] res_o,
  output logic              sat_o
);

  localparam int NSEG = DATA_W / SEG_W;

  logic [1:0]        mask;
  logic [DATA_W-1:0] sum;
  logic [NSEG-1:0]   cout;
  logic [DATA_W-1:0] res_d;
  logic              clamp_any;
  logic [DATA_W-1:0] res_q;
  logic              sat_q;

  assign mask = seg_mask(size_i);

  simd_seg_adder #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_adder (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (sub_i),
    .mask_i (mask),
    .sum_o  (sum),
    .cout_o (cout)
  );

  simd_lane_clamp #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_clamp (
    .a_i         (a_i),
    .b_i         (b_i),
    .sum_i       (sum),
    .cout_i      (cout),
    .mask_i      (mask),
    .signed_i    (signed_i),
    .sat_i       (sat_i),
    .sub_i       (sub_i),
    .res_o       (res_d),
    .clamp_any_o (clamp_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      sat_q <= 1'b0;
    end else begin
      res_q <= res_d;
      // a clamp in the clearing operation still leaves the flag set
      sat_q <= (clr_i ? 1'b0 : sat_q) | clamp_any;
    end
  end

  assign res_o = res_q;
  assign sat_o = sat_q;

endmodule

// File: rtl/simd_sat_add_chk.sv
module simd_sat_add_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              sat_i,
  input logic              clr_i,
  input logic              clamp_any_i,
  input logic [DATA_W-1:0] res_o,
  input logic              sat_o
);

  AST_ZERO_IDENTITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_i == '0) |=> (res_o == $past(a_i))); // R10

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_o && !clr_i) |=> sat_o); // R7

  AST_CLAMP_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_any_i |=> sat_o); // R8

  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !clamp_any_i) |=> !sat_o); // R8

  AST_WRAP_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sat_i && !sat_o) |=> !sat_o); // R9

endmodule

bind simd_sat_add simd_sat_add_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .a_i         (a_i),
  .b_i         (b_i),
  .sat_i       (sat_i),
  .clr_i       (clr_i),
  .clamp_any_i (clamp_any),
  .res_o       (res_o),
  .sat_o       (sat_o)
);

// File: tb/simd_sat_add_bench.sv
`timescale 1ns/1ps
module simd_sat_add_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] a = '0, b = '0;
  logic [1:0]   sz = '0;
  logic         sg = 1'b0, st = 1'b0, sb = 1'b0, clr = 1'b0;
  logic [127:0] res;
  logic         flag;

  int checks = 0;
  int errors = 0;
  logic sticky_m = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [127:0] res;
    logic         flag;
    string        tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  simd_sat_add u_simd_sat_add (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .size_i(sz),
    .signed_i(sg), .sat_i(st), .sub_i(sb), .clr_i(clr),
    .res_o(res), .sat_o(flag)
  );

  // reference built from R2..R6
  function automatic void ref_op(input logic [127:0] x_in, y_in, input logic [1:0] s,
                                 input logic sgn, sat, sub,
                                 output logic [127:0] r, output logic clamp);
    int w;
    int n;
    w = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    n = 128 / w;
    r = '0;
    clamp = 1'b0;
    for (int l = 0; l < n; l++) begin
      longint x, y, z, lo, hi, m;
      logic [127:0] tx, ty;
      m  = (longint'(1) << w) - 1;
      tx = x_in >> (l * w);
      ty = y_in >> (l * w);
      x  = longint'(tx[31:0]) & m;
      y  = longint'(ty[31:0]) & m;
      if (sgn) begin
        if (((x >> (w - 1)) & 1) != 0) x = x - (longint'(1) << w);
        if (((y >> (w - 1)) & 1) != 0) y = y - (longint'(1) << w);
        lo = -(longint'(1) << (w - 1));
        hi = (longint'(1) << (w - 1)) - 1;
      end else begin
        lo = 0;
        hi = m;
      end
      z = sub ? x - y : x + y;
      if (sat && z > hi) begin z = hi; clamp = 1'b1; end
      if (sat && z < lo) begin z = lo; clamp = 1'b1; end
      r = r | (128'(z & m) << (l * w));
    end
  endfunction

  task automatic op(input logic [127:0] xa, xb, input logic [1:0] s,
                    input logic sgn, sat, sub, cl, input string tag);
    item_t it;
    logic [127:0] r;
    logic c;
    @(negedge clk);
    a = xa; b = xb; sz = s; sg = sgn; st = sat; sb = sub; clr = cl;
    ref_op(xa, xb, s, sgn, sat, sub, r, c);
    sticky_m = (cl ? 1'b0 : sticky_m) | c;
    it.res = r; it.flag = sticky_m; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: result of an op driven at a negedge is valid after the next posedge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (res !== it.res) begin
          errors++;
          $display("FAIL %s res actual=%h expected=%h", it.tag, res, it.res);
        end
        checks++;
        if (flag !== it.flag) begin
          errors++;
          $display("FAIL %s flag actual=%0b expected=%0b", it.tag, flag, it.flag);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (res !== '0 || flag !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual=%h/%0b expected=0/0", res, flag);
    end
    rst_n = 1'b1;

    // R2/R4: lane isolation in 8-bit wrap
    op({16{8'hFF}}, {16{8'h01}}, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R2_byte_isolation");
    op({8{16'hFFFF}}, {8{16'h0001}}, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R2_half_isolation");
    op({4{32'h0000_0000}}, {4{32'h0000_0001}}, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, "R2_size3_word_sub");
    // R9: wrap overflow never flags
    op({16{8'h7F}}, {16{8'h01}}, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R9_wrap_no_flag");
    // R3: mixed lanes add and subtract
    op(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 128'h1111_2222_3333_4444_5555_6666_7777_8888,
       2'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R3_add_half");
    op(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 128'h1111_2222_3333_4444_5555_6666_7777_8888,
       2'd2, 1'b1, 1'b0, 1'b1, 1'b0, "R3_sub_word");
    // R5: unsigned saturation both directions
    op({16{8'hF0}}, {16{8'h20}}, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R5_unsigned_max");
    op({8{16'h0010}}, {8{16'h0020}}, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, "R5_unsigned_min_with_clr");
    op('0, '0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R8_clear_only");
    // R6: signed saturation
    op({4{32'h7FFF_FFF0}}, {4{32'h0000_0100}}, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, "R6_signed_max");
    op({16{8'h80}}, {16{8'hFF}}, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, "R6_signed_min");
    op({8{16'h0000}}, {8{16'h8000}}, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, "R6_sub_of_min");
    op({16{8'h10}}, {16{8'h05}}, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, "R7_no_clamp_clear");
    // R7: mixed lanes, one clamps, flag sticks through quiet ops
    op({8'h7F, 120'h0}, {8'h01, 120'h1}, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R7_one_lane_clamps");
    op({16{8'h01}}, {16{8'h01}}, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R7_sticky_hold");
    op({16{8'h01}}, {16{8'h01}}, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R7_sticky_hold_wrap");
    // R8: clear and clamp in the same op leaves flag set
    op({16{8'hFF}}, {16{8'hFF}}, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, "R8_clear_and_clamp");
    op('0, '0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, "R8_clear_after");
    // R10: zero B identity
    op(128'hDEAD_BEEF_8000_0000_7FFF_FFFF_0000_0001, '0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, "R10_zero_sub");
    op(128'hDEAD_BEEF_8000_0000_7FFF_FFFF_0000_0001, '0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R10_zero_add");
    // R1: back-to-back random ops, one per cycle
    for (int i = 0; i < 400; i++) begin
      logic [127:0] ra, rb;
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      if (i % 7 == 0) rb = '0;
      if (i % 5 == 0) ra = {16{8'h80}} ^ ra & {16{8'h0F}};
      op(ra, rb, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
         ($urandom % 8) == 0, "R1_R4_random");
    end
    repeat (4) @(posedge clk);
    #2;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule